// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a 64-word, 16-bit serial EEPROM that sits behind a chip-select, serial-clock and data-in line, with a data-out line that can be released to high impedance. The storage is a register file. A fast system clock samples the three inputs through synchronizers and finds the serial-clock rising edges itself, so the serial side may run at any rate well below the system clock.

A host raises the select line and sends a frame. Any zeros before the first 1 are skipped. After that 1 come a two-bit opcode, a six-bit word address and, for the two data-carrying programming commands, sixteen data bits. Reads stream words out and step the address automatically. Programming commands work only after an enable command. Each one runs a timed internal cycle that begins when the select line drops. If the host raises select during that cycle, the output line reports busy or ready.

The tri-state output is split into a value (`do_o`) and an enable (`do_oe`). A pad cell or a test harness joins them.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset every word holds 16'hFFFF, programming is disabled, and `do_oe` is 0.
- R2: With select high, zeros on `di` are skipped until the first 1 on an `sk` rise. That 1 is the start bit. The next 8 bits are opcode[1:0] then address[5:0], most significant bit first. Data bits, when present, follow with D15 first.
- R3: Opcode 2'b10 reads. On the `sk` rise that captures address bit 0, `do_oe` goes to 1 and `do_o` drives 0. Each later `sk` rise presents the next bit of the addressed word, from D15 down to D0.
- R4: During a read, further `sk` rises after D0 continue with the next address, starting at its D15 with no leading zero. Address 63 is followed by address 0.
- R5: Opcode 2'b01 with 16 data bits replaces the addressed word. The internal cycle starts when select goes low after the last data bit.
- R6: Opcode 2'b00 with address bits [5:4] = 2'b01, followed by 16 data bits, writes that value into all 64 words in one cycle.
- R7: Opcode 2'b11 sets the addressed word to 16'hFFFF. Opcode 2'b00 with address bits [5:4] = 2'b10 sets every word to 16'hFFFF.
- R8: Opcode 2'b00 with address bits [5:4] = 2'b11 enables programming, and 2'b00 disables it. While disabled, write, write-all, erase and erase-all leave every word unchanged. Reads still work.
- R9: If select is raised during a programming cycle, `do_oe` is 1 and `do_o` is 0 while busy and 1 once ready. No frame sent while busy has any effect.
- R10: `do_oe` is 0 within two system clocks after select goes low. A select drop ends a read, and it throws away a partial frame without effect.
- R11: A programming cycle lasts `WR_CYCLES` system clocks. It still reads busy shortly before that count and ready shortly after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; bits are taken on its rising edge |
| di | input | 1 | Serial command, address and data input |
| do_o | output | 1 | Serial read data or busy/ready status value |
| do_oe | output | 1 | Drive enable for `do_o`; 0 means high impedance |

## Verification
A wrong bit counter or a shift register off by one shows up in the same frame, as a missing or misplaced leading zero or as read data shifted by one position. A stale enable flag or a lost pending write only shows up later, when the affected word is read back in a later frame. A wrong cycle counter shows up on the status line when select is raised during the cycle. So the bench reads back words, including neighbours and the wrap from the last address, after every programming step. It also polls status both just before and just after the nominal cycle end.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int AW        = 6,
  parameter int DW        = 16,
  parameter int WR_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = $clog2(DW);
  localparam int CNW   = $clog2(DW + AW + 2);
  localparam int CW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_HOLD} st_t;

  logic [DW-1:0]  mem [DEPTH];
  logic           cs_m, cs_s, sk_m, sk_s, sk_d, di_m, di_s;
  st_t            st;
  logic [CNW-1:0] cnt;
  logic [AW:0]    cmd_sr;
  logic [DW-2:0]  dat_sr;
  logic [AW+1:0]  frame;
  logic [AW-1:0]  rd_addr, pend_addr;
  logic [BW-1:0]  rd_bit, rd_idx;
  logic [DW-1:0]  pend_data;
  logic [CW-1:0]  busy_cnt;
  logic           wen, pend, pend_all, stat, rd_oe, dout, busy, sk_rise;

  assign sk_rise = sk_s & ~sk_d;
  assign frame   = {cmd_sr, di_s};
  assign rd_idx  = BW'(DW - 1) - rd_bit;
  assign busy    = busy_cnt != '0;
  assign do_oe   = cs_s & (rd_oe | stat);
  assign do_o    = stat ? ~busy : dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_m, cs_s, sk_m, sk_s, sk_d, di_m, di_s} <= '0;
      st        <= S_IDLE;
      cnt       <= '0;
      cmd_sr    <= '0;
      dat_sr    <= '0;
      rd_addr   <= '0;
      rd_bit    <= '0;
      pend_addr <= '0;
      pend_data <= '0;
      busy_cnt  <= '0;
      wen       <= 1'b0;
      pend      <= 1'b0;
      pend_all  <= 1'b0;
      stat      <= 1'b0;
      rd_oe     <= 1'b0;
      dout      <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      cs_m <= cs;  cs_s <= cs_m;
      sk_m <= sk;  sk_s <= sk_m;  sk_d <= sk_s;
      di_m <= di;  di_s <= di_m;

      if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == CW'(1)) begin
          if (pend_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= pend_data;
          end else begin
            mem[pend_addr] <= pend_data;
          end
        end
      end

      if (!cs_s) begin
        st    <= S_IDLE;
        rd_oe <= 1'b0;
        if (pend) begin
          pend     <= 1'b0;
          stat     <= 1'b1;
          busy_cnt <= CW'(WR_CYCLES);
        end
      end else if (sk_rise) begin
        case (st)
          S_IDLE: begin
            if (di_s && !busy) begin
              st   <= S_CMD;
              cnt  <= '0;
              stat <= 1'b0;
            end
          end
          S_CMD: begin
            cmd_sr <= frame[AW:0];
            cnt    <= cnt + 1'b1;
            if (cnt == CNW'(AW + 1)) begin
              st        <= S_HOLD;
              cnt       <= '0;
              pend_addr <= frame[AW-1:0];
              pend_all  <= 1'b0;
              pend_data <= '1;
              case (frame[AW+1:AW])
                2'b10: begin
                  st      <= S_READ;
                  rd_addr <= frame[AW-1:0];
                  rd_bit  <= '0;
                  dout    <= 1'b0;
                  rd_oe   <= 1'b1;
                end
                2'b01: st <= S_DATA;
                2'b11: pend <= wen;
                default: begin
                  case (frame[AW-1:AW-2])
                    2'b11: wen <= 1'b1;
                    2'b00: wen <= 1'b0;
                    2'b01: begin
                      st       <= S_DATA;
                      pend_all <= 1'b1;
                    end
                    default: begin
                      pend     <= wen;
                      pend_all <= 1'b1;
                    end
                  endcase
                end
              endcase
            end
          end
          S_DATA: begin
            dat_sr <= {dat_sr[DW-3:0], di_s};
            cnt    <= cnt + 1'b1;
            if (cnt == CNW'(DW - 1)) begin
              st        <= S_HOLD;
              pend      <= wen;
              pend_data <= {dat_sr, di_s};
            end
          end
          S_READ: begin
            dout <= mem[rd_addr][rd_idx];
            if (rd_bit == BW'(DW - 1)) begin
              rd_bit  <= '0;
              rd_addr <= rd_addr + 1'b1;
            end else begin
              rd_bit <= rd_bit + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic cs_s,
  input logic do_o,
  input logic do_oe,
  input logic busy,
  input logic wen
);
  AST_DO_Z_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs, 2) |-> !do_oe); // R10

  AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && do_oe |-> !do_o); // R9

  AST_PROG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen); // R8

  AST_CYCLE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cs_s)); // R5
endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .cs_s(cs_s),
  .do_o(do_o), .do_oe(do_oe), .busy(busy), .wen(wen)
);

// File: tb/uwire_eeprom_test.sv
module uwire_eeprom_test;
  localparam int AW = 6, DW = 16, WR = 1000, H = 6, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [DEPTH];
  logic [1:0] q_exp[$];
  string q_tag[$];
  event mon_ev;
  logic [1:0] got, want;
  string tag_now;

  always #2 clk = ~clk;

  uwire_eeprom #(.AW(AW), .DW(DW), .WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe)
  );

  always begin
    @(mon_ev);
    total++;
    got = {do_oe, do_o};
    if (q_exp.size() == 0) begin
      bad++;
      $display("FAIL scoreboard empty: got %b expected no sample", got);
    end else begin
      want    = q_exp.pop_front();
      tag_now = q_tag.pop_front();
      if (want[1] ? (got !== want) : (do_oe !== 1'b0)) begin
        bad++;
        $display("FAIL %s: {oe,do}=%b expected %b", tag_now, got, want);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic expect_do(input logic oe, input logic v, input string tag);
    q_exp.push_back({oe, v});
    q_tag.push_back(tag);
    ->mon_ev;
  endtask

  task automatic clk_bit(input logic b, input bit chk, input logic v, input string tag);
    @(negedge clk) di = b;
    repeat (H) @(negedge clk);
    sk = 1'b1;
    repeat (H) @(negedge clk);
    if (chk) expect_do(1'b1, v, tag);
    sk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i], 1'b0, 1'b0, "");
  endtask

  task automatic sel();
    @(negedge clk) cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk);
    cs = 1'b0;
    di = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic prog(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d, input bit has_d);
    sel();
    send(32'({1'b1, op, a}), 9);
    if (has_d) send(32'(d), 16);
    desel();
    repeat (WR + 20) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input int words, input int zeros, input string tag);
    logic [5:0] p;
    sel();
    if (zeros > 0) send(32'd0, zeros);
    send(32'({1'b1, 2'b10, a[5:1]}), 8);
    clk_bit(a[0], 1'b1, 1'b0, {tag, " dummy"});
    p = a;
    for (int w = 0; w < words; w++) begin
      for (int i = DW - 1; i >= 0; i--) clk_bit(1'b0, 1'b1, model[p][i], tag);
      p = p + 1'b1;
    end
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_do(1'b0, 1'b0, "R1 reset output released");
    rd(6'd5, 1, 0, "R1 R3");
    rd(6'd63, 1, 0, "R1 R3");

    prog(2'b01, 6'd3, 16'h1234, 1'b1);
    rd(6'd3, 1, 0, "R1 R8 disabled after reset");

    prog(2'b00, 6'b110000, 16'h0, 1'b0);
    prog(2'b01, 6'd3, 16'h1234, 1'b1);
    model[3] = 16'h1234;
    rd(6'd3, 1, 0, "R5");
    rd(6'd2, 2, 3, "R2 R4");

    // R11 cycle length
    sel();
    send(32'({1'b1, 2'b01, 6'd40}), 9);
    send(32'h0000F00F, 16);
    @(negedge clk);
    cs = 1'b0;
    di = 1'b0;
    repeat (6) @(negedge clk);
    cs = 1'b1;
    repeat (WR - 150) @(negedge clk);
    expect_do(1'b1, 1'b0, "R11 busy before end");
    repeat (200) @(negedge clk);
    expect_do(1'b1, 1'b1, "R11 ready after end");
    model[40] = 16'hF00F;
    desel();
    rd(6'd40, 1, 0, "R11 R5");

    // R9 status and busy lockout
    sel();
    send(32'({1'b1, 2'b01, 6'd10}), 9);
    send(32'h0000ABCD, 16);
    @(negedge clk);
    cs = 1'b0;
    di = 1'b0;
    repeat (6) @(negedge clk);
    cs = 1'b1;
    repeat (6) @(negedge clk);
    expect_do(1'b1, 1'b0, "R9 busy status");
    send(32'({1'b1, 2'b01, 6'd11}), 9);
    send(32'h00000F0F, 16);
    expect_do(1'b1, 1'b0, "R9 still busy");
    desel();
    repeat (WR + 20) @(negedge clk);
    model[10] = 16'hABCD;
    rd(6'd11, 1, 0, "R9 frame while busy ignored");
    rd(6'd10, 1, 0, "R9 R5");

    // R10 read abort
    sel();
    send(32'({1'b1, 2'b10, 5'b00001}), 8);
    clk_bit(1'b1, 1'b1, 1'b0, "R10 dummy");
    for (int i = DW - 1; i > DW - 6; i--) clk_bit(1'b0, 1'b1, model[3][i], "R10 partial read");
    @(negedge clk) cs = 1'b0;
    repeat (3) @(negedge clk);
    expect_do(1'b0, 1'b0, "R10 released after select low");
    repeat (6) @(negedge clk);

    // R10 partial write discarded
    sel();
    send(32'({1'b1, 2'b01, 6'd7}), 9);
    send(32'h000000AA, 8);
    desel();
    repeat (WR + 20) @(negedge clk);
    rd(6'd7, 1, 0, "R10 partial write");

    prog(2'b11, 6'd3, 16'h0, 1'b0);
    model[3] = '1;
    rd(6'd3, 1, 0, "R7 erase");

    prog(2'b00, 6'b010000, 16'h5A5A, 1'b1);
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h5A5A;
    rd(6'd63, 2, 0, "R6 R4 wrap");

    prog(2'b00, 6'b100000, 16'h0, 1'b0);
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    rd(6'd20, 1, 0, "R7 erase-all");

    prog(2'b01, 6'd20, 16'hC3C3, 1'b1);
    model[20] = 16'hC3C3;
    prog(2'b00, 6'b000000, 16'h0, 1'b0);
    prog(2'b01, 6'd20, 16'h0000, 1'b1);
    prog(2'b11, 6'd20, 16'h0, 1'b0);
    prog(2'b00, 6'b010000, 16'h1111, 1'b1);
    rd(6'd20, 1, 0, "R8 disabled");
    rd(6'd21, 1, 0, "R8 disabled");

    finish_run();
  end
endmodule